// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port Controller

This block manages a row of general-purpose pins through two registers on a small synchronous register bus. The configuration register packs two bits per pin. One bit picks the pin's direction. The other bit asks for or declines the pin's internal pull-up resistor. The data register is a latch whose bits are driven onto every pin set up as an output.

Reading the data register gives a mixed word. Each output pin contributes its latched bit, and each input pin contributes its pad level after that level has passed through a synchroniser on the bus clock. Toward the pad ring the block presents three per-pin vectors: output enable, output data and pull-up enable. It takes one vector of raw pin levels.

Reset clears the configuration register, so every pin comes up as an input with its pull-up on. Reset leaves the data latch alone, and the latch's power-up value is unknown.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `pad_oe` is all zeros, `pad_pu_en` is all ones and `bus_rdata` is zero.
- R2: The configuration register (address 0) holds pin n's direction bit at bit position 2n and its pull-up control bit at position 2n+1. A configuration read returns the last word written to it.
- R3: `pad_oe[n]` equals pin n's direction bit, where 1 means output and 0 means input. It takes the new value on the cycle after a configuration write.
- R4: `pad_pu_en[n]` is 1 only when pin n's pull-up control bit is 0 and its direction bit is 0. An output pin never has its pull-up enabled.
- R5: A write to the data register (address 1) loads `bus_wdata[15:0]` into the latch even for pins that are inputs. `pad_out` always shows the latch, so a pin switched to output drives the value stored earlier.
- R6: In a data read result, bit n is the latch bit when pin n is an output and the synchronised pad level when pin n is an input. Bits 31:16 read as zero.
- R7: A change on `pad_in` reaches a data read only after two bus clock edges. A read issued in the same cycle as the change, or in the next cycle, returns the old level. A read issued two cycles later returns the new level.
- R8: A read (select high, write strobe low) puts its result on `bus_rdata` on the next cycle. `bus_rdata` keeps that value until the next read.
- R9: Reset does not change the data latch. The value written before reset is still on `pad_out` after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = configuration, 1 = data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| pad_pu_en | output | 16 | Per-pin pull-up enable, active high |
| pad_in | input | 16 | Raw pin levels |

## Verification
The bench drives configuration words that mix input, output, pull-up-on and pull-up-off pins within a single word. This catches a design that swaps the two bits of a pair, or one that lets a pull-up stay on for an output pin. It writes the latch while pins are inputs and then turns them into outputs, which exposes a design that drops writes to input pins. A reset pulse placed between a latch write and its readback shows whether the latch gets cleared by mistake. Reads timed on the exact cycle after a pin change catch a synchroniser with too few stages or too many. Idle cycles with the pins moving catch read data that is not held between reads.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port controller.
// Assumes a register bus with a single address bit.
package gpio_pkg;
    localparam int BUS_W = 32;

    typedef enum logic {
        REG_CFG  = 1'b0,
        REG_DATA = 1'b1
    } gpio_reg_e;
endpackage

// File: rtl/gpio_cfg_reg.sv
// Configuration register: holds one direction bit and one pull-up control bit per pin.
// The two bits of a pin are interleaved: direction at bit 2n, pull-up control at 2n+1.
// Assumes 2*NUM_PINS <= BUS_W. Reset clears the register, so all pins become inputs with pull-ups on.
module gpio_cfg_reg #(
    parameter int NUM_PINS = 16,
    parameter int BUS_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BUS_W-1:0]      wdata,
    output logic [2*NUM_PINS-1:0] cfg_q,
    output logic [NUM_PINS-1:0]   dir_out,
    output logic [NUM_PINS-1:0]   pu_off
);
    localparam int CFG_W = 2 * NUM_PINS;

    // Register update: cleared by reset, loaded on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wdata[CFG_W-1:0];
        end
    end

    // Split the interleaved pairs into separate per-pin vectors.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_split
        assign dir_out[n] = cfg_q[2*n];
        assign pu_off[n]  = cfg_q[2*n+1];
    end
endmodule

// File: rtl/gpio_data_latch.sv
// Data latch register for the port. Reset does not touch it, so it keeps its contents
// across resets and starts with an unknown value. Every write loads all bits,
// whatever the direction of each pin.
module gpio_data_latch #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] latch_q
);
    // Load on write only; deliberately left without a reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            latch_q <= wdata;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchroniser that brings the raw pad levels into the bus clock domain.
// STAGES sets the number of flops in the chain and must be at least 1.
// Reset clears every stage to zero.
module gpio_in_sync #(
    parameter int NUM_PINS = 16,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_sync
);
    logic [NUM_PINS-1:0] chain [STAGES];

    // The first stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pin_raw;
    end

    // Each later stage re-registers the stage before it.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_drive.sv
// Builds the per-pin pad controls from the configuration and the data latch.
// Output enable follows the direction bit and output data follows the latch.
// The pull-up is on only for an input pin whose pull-up control bit is 0.
module gpio_pad_drive #(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0] dir_out,
    input  logic [NUM_PINS-1:0] pu_off,
    input  logic [NUM_PINS-1:0] latch_q,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu_en
);
    // Per-pin drive logic; an output pin always has its pull-up forced off.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign pad_oe[n]    = dir_out[n];
        assign pad_out[n]   = latch_q[n];
        assign pad_pu_en[n] = ~pu_off[n] & ~dir_out[n];
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
// GPIO port controller top level. It decodes the register bus, holds the configuration
// register and data latch, synchronises the pad inputs and returns read data one cycle
// after the request. Assumes single-cycle accesses and a synchronous active-low reset.
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu_en,
    input  logic [NUM_PINS-1:0] pad_in
);
    localparam int CFG_W = 2 * NUM_PINS;

    logic                cfg_we, data_we, rd_req;
    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] dir_out, pu_off, latch_q, pin_sync, data_view;
    logic [BUS_W-1:0]    rd_next;

    // Bus decode into the two write enables and a read request.
    always_comb begin
        cfg_we  = bus_sel &  bus_wr & (gpio_reg_e'(bus_addr) == REG_CFG);
        data_we = bus_sel &  bus_wr & (gpio_reg_e'(bus_addr) == REG_DATA);
        rd_req  = bus_sel & ~bus_wr;
    end

    gpio_cfg_reg #(.NUM_PINS(NUM_PINS), .BUS_W(BUS_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wdata(bus_wdata),
        .cfg_q(cfg_q), .dir_out(dir_out), .pu_off(pu_off)
    );

    gpio_data_latch #(.NUM_PINS(NUM_PINS)) i_latch (
        .clk(clk), .wr_en(data_we), .wdata(bus_wdata[NUM_PINS-1:0]), .latch_q(latch_q)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pad_in), .pin_sync(pin_sync)
    );

    gpio_pad_drive #(.NUM_PINS(NUM_PINS)) i_drive (
        .dir_out(dir_out), .pu_off(pu_off), .latch_q(latch_q),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en)
    );

    // Per-pin read view: the latch for output pins, the synchronised pad level for input pins.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_view
        assign data_view[n] = dir_out[n] ? latch_q[n] : pin_sync[n];
    end

    // Select the register being read and zero-extend it to the bus width.
    always_comb begin
        rd_next = '0;
        if (gpio_reg_e'(bus_addr) == REG_CFG) rd_next[CFG_W-1:0]    = cfg_q;
        else                                  rd_next[NUM_PINS-1:0] = data_view;
    end

    // Read data register: loaded on a read request, held at all other times.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
// Assertion checker for gpio_port_ctrl, attached with bind. It watches only the top-level ports.
module gpio_port_ctrl_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic                bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_pu_en,
    input logic [NUM_PINS-1:0] pad_in
);
    logic [NUM_PINS-1:0] w_dir, w_puc;

    // Split the write word into per-pin fields for comparison.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            w_dir[n] = bus_wdata[2*n];
            w_puc[n] = bus_wdata[2*n+1];
        end
    end

    // R2 R3: a configuration write shows up on the pad controls on the next cycle.
    p_cfg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr) |=> (pad_oe == $past(w_dir)));

    // R4: the pull-up follows the written control bits with output pins forced off.
    p_cfg_pullup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr) |=> (pad_pu_en == $past(~w_puc & ~w_dir)));

    // R4: an output pin never has its pull-up enabled.
    p_no_pu_on_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_en & pad_oe) == '0);

    // R5: a data write lands on the pad output data on the next cycle.
    p_data_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr) |=> (pad_out == $past(bus_wdata[NUM_PINS-1:0])));

    // R6: output pins read back as the driven value, and the upper bits read as zero.
    p_read_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr) |=>
        (((bus_rdata[NUM_PINS-1:0] ^ $past(pad_out)) & $past(pad_oe)) == '0)
        && (bus_rdata[31:NUM_PINS] == '0));

    // R8: read data holds its value when no read is requested.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu_en(pad_pu_en), .pad_in(pad_in)
);

// File: tb/test_gpio_port_ctrl.sv
// Self-checking bench for gpio_port_ctrl: a table walk, then directed tests.
module test_gpio_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_oe, pad_out, pad_pu_en;
    logic [15:0] pad_in = '0;
    int          n_run = 0, n_fail = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu_en(pad_pu_en), .pad_in(pad_in)
    );

    // Each entry: {configuration word, data word, pad levels}.
    localparam logic [63:0] VEC [6] = '{
        {32'h0000_0000, 16'h1234, 16'hABCD},
        {32'h5555_5555, 16'h1234, 16'hABCD},
        {32'hAAAA_AAAA, 16'hFFFF, 16'h0F0F},
        {32'h9999_9999, 16'hC3A5, 16'h5A3C},
        {32'hFFFF_0000, 16'h00FF, 16'hF0F0},
        {32'h0000_FFFF, 16'h8001, 16'h7FFE}
    };

    function automatic logic [15:0] even_bits(input logic [31:0] w);
        for (int n = 0; n < 16; n++) even_bits[n] = w[2*n];
    endfunction

    function automatic logic [15:0] odd_bits(input logic [31:0] w);
        for (int n = 0; n < 16; n++) odd_bits[n] = w[2*n+1];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] c;
        logic [15:0] d, p, dir;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held.
        check("R1 oe in reset", {16'h0, pad_oe}, 32'h0);
        check("R1 pu in reset", {16'h0, pad_pu_en}, 32'h0000_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", {16'h0, pad_oe}, 32'h0);
        check("R1 pu after reset", {16'h0, pad_pu_en}, 32'h0000_FFFF);
        check("R1 rdata after reset", bus_rdata, 32'h0);

        // Table walk over mixed configurations (R2 R3 R4 R5 R6).
        for (int i = 0; i < 6; i++) begin
            c = VEC[i][63:32]; d = VEC[i][31:16]; p = VEC[i][15:0];
            dir = even_bits(c);
            bus_write(1'b1, {16'h0, d});
            bus_write(1'b0, c);
            pad_in = p;
            repeat (3) @(negedge clk);
            check("R3 oe", {16'h0, pad_oe}, {16'h0, dir});
            check("R4 pull-up", {16'h0, pad_pu_en}, {16'h0, ~odd_bits(c) & ~dir});
            check("R5 pad_out", {16'h0, pad_out}, {16'h0, d});
            bus_read(1'b1, rd);
            check("R6 data read", rd, {16'h0, (dir & d) | (~dir & p)});
            bus_read(1'b0, rd);
            check("R2 cfg read", rd, c);
        end

        // R5: write the latch while all pins are inputs, then switch them to outputs.
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, 32'hFFFF_6C39);
        bus_write(1'b0, 32'h5555_5555);
        check("R5 latch written while input", {16'h0, pad_out}, 32'h0000_6C39);
        bus_read(1'b1, rd);
        check("R5 readback after switch", rd, 32'h0000_6C39);

        // R9: a reset pulse leaves the latch unchanged.
        bus_write(1'b1, 32'h0000_A55A);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R9 oe cleared", {16'h0, pad_oe}, 32'h0);
        bus_write(1'b0, 32'h5555_5555);
        check("R9 latch kept", {16'h0, pad_out}, 32'h0000_A55A);

        // R7: synchroniser latency on input pins.
        bus_write(1'b0, 32'h0);
        pad_in = 16'h0000;
        repeat (4) @(negedge clk);
        pad_in = 16'hFFFF;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
        @(negedge clk);
        check("R7 read same cycle", bus_rdata, 32'h0);
        @(negedge clk);
        check("R7 read one cycle later", bus_rdata, 32'h0);
        @(negedge clk);
        bus_sel = 1'b0;
        check("R7 read two cycles later", bus_rdata, 32'h0000_FFFF);

        // R8: read data holds while idle even though the pins move.
        pad_in = 16'h1111;
        repeat (5) @(negedge clk);
        check("R8 rdata held", bus_rdata, 32'h0000_FFFF);
        bus_read(1'b1, rd);
        check("R8 next read updates", rd, 32'h0000_1111);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule